// File: doc/BRIEF.md
# Banked Register File with Operand Collectors

This block is a 128-entry, 64-bit register file. It is built from eight banks. Each bank has one read port and one write port, and each bank access moves a group of four consecutive registers (256 bits). A free-running four-phase slot counter shares the banks between operand reads and result writes. Phases 0, 1 and 2 read the first, second and third source groups of an issue window. Phase 3 is the write slot for execution results. The source groups are collected in flip-flops and presented together in phase 3.

A window that does not use its third operand leaves phase 2 free. That free slot is lent to a one-entry memory holding register, which serves either a store-data read or a load-result write. Results from the execution unit may arrive in any cycle. They wait in a one-entry pending register until the next write slot. While they wait, any operand read of the same group receives the pending data.

Each cycle the block drives a clock-enable for the single bank it touches. Every other bank's enable is low.

Top module: `opcol_regfile`

## Requirements
- R1: `slot` is 0 in the first cycle after reset and then counts 0,1,2,3 and wraps, advancing by one each clock. `iss_ready` is high exactly when `slot` is 0.
- R2: An issue accepted in slot 0 reads source group `iss_src1` in slot 0, `iss_src2` in slot 1, and `iss_src3` in slot 2 (only when `iss_use3` is 1). `opnd_valid` is high for one cycle, in the following slot 3, with the three groups on `opnd_a`, `opnd_b` and `opnd_c`. `opnd_c` is all zero when `iss_use3` is 0.
- R3: Register r lives in group r/4, lane r mod 4, at bits [64*lane+63 : 64*lane] of the 256-bit group. Group g lives in bank g mod 8, row g/8.
- R4: Register 0 (bits [63:0] of group 0) always reads as zero, whether it was written by a result or by a load. The other lanes of group 0 hold their written data.
- R5: A result offered with `wr_valid` is taken on an edge where `wr_ready` is high. It is written to its bank in the next slot-3 cycle. While a result is pending, `wr_ready` is low in every slot except slot 3.
- R6: If an operand or store read addresses a group whose result write is still pending, it returns the pending data instead of the bank's stored data.
- R7: `mem_req_ready` is high exactly when the holding register is empty. A held request is served only in slot 2, and only when the current window does not read a third operand or no window is active.
- R8: A store request (`mem_req_load` = 0) is answered with `mem_rvalid` high for one cycle in the slot-3 cycle right after its grant, carrying the group on `mem_rdata`.
- R9: A load request writes its group during its granted slot. While the load is held, operand reads of that group return the held load data.
- R10: `bank_ce` has at most one bit set. It is the bit of bank (group mod 8) for the group read or written in that cycle, and it is zero in a cycle with no access.
- R11: Reset clears the collectors, `opnd_valid`, `mem_rvalid`, the pending result and the memory holding register. Register contents other than register 0 are undefined after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request for a window |
| iss_ready | output | 1 | High in slot 0, when an issue is taken |
| iss_src1 | input | 5 | First source group |
| iss_src2 | input | 5 | Second source group |
| iss_src3 | input | 5 | Third source group |
| iss_use3 | input | 1 | Window needs its third operand |
| opnd_valid | output | 1 | Collected operands valid (slot 3) |
| opnd_a | output | 256 | First source group |
| opnd_b | output | 256 | Second source group |
| opnd_c | output | 256 | Third source group or zero |
| wr_valid | input | 1 | Execution result offered |
| wr_ready | output | 1 | Result can be taken this cycle |
| wr_grp | input | 5 | Destination group |
| wr_data | input | 256 | Result data |
| mem_req_valid | input | 1 | Memory-port request offered |
| mem_req_ready | output | 1 | Holding register is empty |
| mem_req_load | input | 1 | 1 = load write, 0 = store read |
| mem_req_grp | input | 5 | Group for the memory access |
| mem_req_data | input | 256 | Load data |
| mem_rvalid | output | 1 | Store data valid |
| mem_rdata | output | 256 | Store data |
| slot | output | 2 | Current schedule phase |
| bank_ce | output | 8 | Per-bank clock-enables |

## Verification
If the slot counter drifts from its window, the very next `opnd_valid` lands outside slot 3, or a store answer comes back one window late. A lost or stale forwarding path shows up at once in the operands collected by a window that overlaps a pending result or a held load: one operand carries the new data and another carries the old. A wrong bank mapping shows up within one cycle on `bank_ce`, and a wrong row mapping shows up as crossed data when the full set of groups is read back.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
  localparam int REG_W  = 64;
  localparam int LANES  = 4;
  localparam int NREGS  = 128;
  localparam int NBANKS = 8;
  localparam int GRP_W  = REG_W * LANES;
  localparam int NGRP   = NREGS / LANES;
  localparam int GIDX_W = $clog2(NGRP);
  localparam int BANK_W = $clog2(NBANKS);
  localparam int ROWS   = NGRP / NBANKS;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;

  typedef logic [GIDX_W-1:0] gidx_t;
  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [BANK_W-1:0] bidx_t;
  typedef logic [ROW_W-1:0]  ridx_t;

  // low group bits pick the bank, the rest pick the row inside it
  function automatic bidx_t bank_of(gidx_t g);
    return g[BANK_W-1:0];
  endfunction

  function automatic ridx_t row_of(gidx_t g);
    return ridx_t'(g >> BANK_W);
  endfunction

  // register 0 is lane 0 of group 0 and is hardwired to zero
  function automatic grp_t hardwire_r0(gidx_t g, grp_t d);
    grp_t r;
    r = d;
    if (g == '0) r[REG_W-1:0] = '0;
    return r;
  endfunction
endpackage

// File: rtl/rfc_bank.sv
`timescale 1ns/1ps
module rfc_bank #(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int DW    = 256
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] wrow,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rrow,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (ce && we) store[wrow] <= wdata;
  end

  assign rdata = ce ? store[rrow] : '0;
endmodule

// File: rtl/rfc_sched.sv
`timescale 1ns/1ps
module rfc_sched import rfc_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iss_valid,
  input  gidx_t      iss_s1,
  input  gidx_t      iss_s2,
  input  gidx_t      iss_s3,
  input  logic       iss_use3,
  output logic [1:0] phase,
  output logic       rd_en,
  output gidx_t      rd_grp,
  output logic       cap_a,
  output logic       cap_b,
  output logic       cap_c,
  output logic       clr_c,
  output logic       mem_free,
  output logic       win_done
);
  logic  win_v, w_use3;
  gidx_t w_s2, w_s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= 2'd0;
      win_v  <= 1'b0;
      w_use3 <= 1'b0;
      w_s2   <= '0;
      w_s3   <= '0;
    end else begin
      phase <= phase + 2'd1;
      if (phase == 2'd0) begin
        win_v  <= iss_valid;
        w_use3 <= iss_use3;
        w_s2   <= iss_s2;
        w_s3   <= iss_s3;
      end else if (phase == 2'd3) begin
        win_v <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_en  = 1'b0;
    rd_grp = iss_s1;
    cap_a  = 1'b0;
    cap_b  = 1'b0;
    cap_c  = 1'b0;
    unique case (phase)
      2'd0: if (iss_valid) begin rd_en = 1'b1; rd_grp = iss_s1; cap_a = 1'b1; end
      2'd1: if (win_v) begin rd_en = 1'b1; rd_grp = w_s2; cap_b = 1'b1; end
      2'd2: if (win_v && w_use3) begin rd_en = 1'b1; rd_grp = w_s3; cap_c = 1'b1; end
      default: ;
    endcase
  end

  assign clr_c    = (phase == 2'd2) && win_v && !w_use3;
  assign mem_free = (phase == 2'd2) && !(win_v && w_use3);
  assign win_done = (phase == 2'd2) && win_v;

  a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == $past(phase) + 2'd1);

  // R7: the lent slot never coincides with an operand read
  a_r7_free_slot_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_free |-> !rd_en);
endmodule

// File: rtl/rfc_memhold.sv
`timescale 1ns/1ps
module rfc_memhold import rfc_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  logic  in_load,
  input  gidx_t in_grp,
  input  grp_t  in_data,
  input  logic  grant,
  output logic  h_v,
  output logic  h_load,
  output gidx_t h_grp,
  output grp_t  h_data
);
  assign in_ready = !h_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_v    <= 1'b0;
      h_load <= 1'b0;
      h_grp  <= '0;
      h_data <= '0;
    end else if (grant) begin
      h_v <= 1'b0;
    end else if (in_valid && in_ready) begin
      h_v    <= 1'b1;
      h_load <= in_load;
      h_grp  <= in_grp;
      h_data <= in_data;
    end
  end

  a_r7_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    h_v && !grant |=> h_v && $stable(h_grp) && $stable(h_load));
endmodule

// File: rtl/opcol_regfile.sv
`timescale 1ns/1ps
module opcol_regfile import rfc_pkg::*; (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         iss_valid,
  output logic         iss_ready,
  input  logic [4:0]   iss_src1,
  input  logic [4:0]   iss_src2,
  input  logic [4:0]   iss_src3,
  input  logic         iss_use3,
  output logic         opnd_valid,
  output logic [255:0] opnd_a,
  output logic [255:0] opnd_b,
  output logic [255:0] opnd_c,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [4:0]   wr_grp,
  input  logic [255:0] wr_data,
  input  logic         mem_req_valid,
  output logic         mem_req_ready,
  input  logic         mem_req_load,
  input  logic [4:0]   mem_req_grp,
  input  logic [255:0] mem_req_data,
  output logic         mem_rvalid,
  output logic [255:0] mem_rdata,
  output logic [1:0]   slot,
  output logic [7:0]   bank_ce
);
  logic  rd_en, cap_a, cap_b, cap_c, clr_c, mem_free, win_done;
  gidx_t rd_grp;
  logic  h_v, h_load;
  gidx_t h_grp;
  grp_t  h_data;
  logic  pv;
  gidx_t pg;
  grp_t  pd;
  logic  grant, commit;
  logic  acc_en, acc_we;
  gidx_t acc_grp;
  grp_t  acc_wdata, acc_raw, acc_val;
  grp_t  bank_rd [NBANKS];
  grp_t  col_a, col_b, col_c;

  rfc_sched u_sched (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
    .iss_s1(iss_src1), .iss_s2(iss_src2), .iss_s3(iss_src3), .iss_use3(iss_use3),
    .phase(slot), .rd_en(rd_en), .rd_grp(rd_grp),
    .cap_a(cap_a), .cap_b(cap_b), .cap_c(cap_c), .clr_c(clr_c),
    .mem_free(mem_free), .win_done(win_done)
  );

  rfc_memhold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(mem_req_valid), .in_ready(mem_req_ready),
    .in_load(mem_req_load), .in_grp(mem_req_grp), .in_data(mem_req_data),
    .grant(grant), .h_v(h_v), .h_load(h_load), .h_grp(h_grp), .h_data(h_data)
  );

  assign iss_ready = (slot == 2'd0);
  assign grant     = mem_free && h_v;
  assign commit    = (slot == 2'd3) && pv;
  assign wr_ready  = !pv || (slot == 2'd3);

  // one bank access per cycle: operand read, lent memory slot, or result write
  always_comb begin
    acc_en    = 1'b0;
    acc_we    = 1'b0;
    acc_grp   = rd_grp;
    acc_wdata = pd;
    if (rd_en) begin
      acc_en = 1'b1;
    end else if (grant) begin
      acc_en    = 1'b1;
      acc_we    = h_load;
      acc_grp   = h_grp;
      acc_wdata = h_data;
    end else if (commit) begin
      acc_en  = 1'b1;
      acc_we  = 1'b1;
      acc_grp = pg;
    end
  end

  always_comb begin
    bank_ce = '0;
    if (acc_en) bank_ce[bank_of(acc_grp)] = 1'b1;
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    rfc_bank #(.DEPTH(ROWS), .AW(ROW_W), .DW(GRP_W)) u_bank (
      .clk(clk), .ce(bank_ce[b]), .we(acc_we), .wrow(row_of(acc_grp)),
      .wdata(acc_wdata), .rrow(row_of(acc_grp)), .rdata(bank_rd[b])
    );
  end

  assign acc_raw = bank_rd[bank_of(acc_grp)];

  // pending result first, then a held load, then storage
  always_comb begin
    if (pv && pg == acc_grp)                   acc_val = hardwire_r0(acc_grp, pd);
    else if (h_v && h_load && h_grp == acc_grp) acc_val = hardwire_r0(acc_grp, h_data);
    else                                        acc_val = hardwire_r0(acc_grp, acc_raw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_a      <= '0;
      col_b      <= '0;
      col_c      <= '0;
      opnd_valid <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      pv         <= 1'b0;
      pg         <= '0;
      pd         <= '0;
    end else begin
      if (cap_a) col_a <= acc_val;
      if (cap_b) col_b <= acc_val;
      if (cap_c)      col_c <= acc_val;
      else if (clr_c) col_c <= '0;
      opnd_valid <= win_done;
      mem_rvalid <= grant && !h_load;
      if (grant && !h_load) mem_rdata <= acc_val;
      if (wr_valid && wr_ready) begin
        pv <= 1'b1;
        pg <= wr_grp;
        pd <= wr_data;
      end else if (commit) begin
        pv <= 1'b0;
      end
    end
  end

  assign opnd_a = col_a;
  assign opnd_b = col_b;
  assign opnd_c = col_c;

  a_r10_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_ce));

  a_r2_operands_in_slot3: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid |-> slot == 2'd3);

  a_r7_grant_in_lent_slot: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> slot == 2'd2 && !rd_en);

  a_r5_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pv && slot != 2'd3 |=> pv && $stable(pg));

  a_r8_store_answer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> slot == 2'd3);
endmodule

// File: tb/opcol_regfile_bench.sv
`timescale 1ns/1ps
module opcol_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_ready, iss_use3 = 1'b0;
  logic [4:0] iss_src1 = '0, iss_src2 = '0, iss_src3 = '0;
  logic opnd_valid;
  logic [255:0] opnd_a, opnd_b, opnd_c;
  logic wr_valid = 1'b0, wr_ready;
  logic [4:0] wr_grp = '0;
  logic [255:0] wr_data = '0;
  logic mem_req_valid = 1'b0, mem_req_ready, mem_req_load = 1'b0;
  logic [4:0] mem_req_grp = '0;
  logic [255:0] mem_req_data = '0;
  logic mem_rvalid;
  logic [255:0] mem_rdata;
  logic [1:0] slot;
  logic [7:0] bank_ce;

  int nchk = 0, nfail = 0;
  int salt_m [32];

  always #4 clk = ~clk;

  opcol_regfile u_opcol_regfile (.*);

  function automatic logic [255:0] pat(int g, int salt);
    logic [255:0] v;
    for (int l = 0; l < 4; l++)
      v[64*l +: 64] = {16'(salt), 8'(g), 8'(l), 32'hC0DE0000 | 32'(g*4 + l)};
    return v;
  endfunction

  function automatic logic [255:0] expv(int g, int salt);
    logic [255:0] v;
    v = pat(g, salt);
    if (g == 0) v[63:0] = '0;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_slot(input int s);
    @(negedge clk);
    while (slot != 2'(s)) @(negedge clk);
  endtask

  task automatic do_write(input int g, input int salt);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_grp = 5'(g); wr_data = pat(g, salt);
    @(negedge clk);
    wr_valid = 1'b0;
    salt_m[g] = salt;
    if (slot != 2'd3) chk(wr_ready == 1'b0, "R5 wr_ready low while pending", 256'(wr_ready), 256'(0));
  endtask

  task automatic run_window(input int s1, input int s2, input int s3, input bit u3,
                            input bit dw, input int wg, input int ws,
                            input bit dm, input bit ml, input int mg, input int ms,
                            output logic [255:0] a, output logic [255:0] b, output logic [255:0] c,
                            output logic rv, output logic [255:0] rd, output logic [7:0] ce0);
    wait_slot(0);
    iss_valid = 1'b1; iss_src1 = 5'(s1); iss_src2 = 5'(s2); iss_src3 = 5'(s3); iss_use3 = u3;
    if (dw) begin wr_valid = 1'b1; wr_grp = 5'(wg); wr_data = pat(wg, ws); end
    if (dm) begin
      mem_req_valid = 1'b1; mem_req_load = ml; mem_req_grp = 5'(mg); mem_req_data = pat(mg, ms);
    end
    #1 ce0 = bank_ce;
    @(negedge clk);
    iss_valid = 1'b0; wr_valid = 1'b0; mem_req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(opnd_valid == 1'b1 && slot == 2'd3, "R2 opnd_valid in slot 3", 256'(opnd_valid), 256'(1));
    a = opnd_a; b = opnd_b; c = opnd_c; rv = mem_rvalid; rd = mem_rdata;
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [255:0] a, b, c, rd, e;
    logic rv;
    logic [7:0] ce0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(slot == 2'd0, "R1 slot after reset", 256'(slot), 256'(0));
    chk(opnd_valid == 1'b0 && opnd_a == '0 && opnd_c == '0, "R11 collectors cleared", opnd_a, '0);
    chk(wr_ready && mem_req_ready && !mem_rvalid, "R11 pending and holding empty",
        256'({wr_ready, mem_req_ready, mem_rvalid}), 256'(3'b110));
    chk(bank_ce == 8'd0, "R10 idle bank_ce", 256'(bank_ce), 256'(0));
    // R1 slot sequence
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      chk(slot == 2'(i % 4) && iss_ready == (i % 4 == 0), "R1 slot sequence",
          256'({iss_ready, slot}), 256'({i % 4 == 0, 2'(i % 4)}));
    end
    // fill every group through the result port
    for (int g = 0; g < 32; g++) do_write(g, 1);
    // R3 sweep over all groups and banks
    for (int g = 0; g < 32; g++) begin
      int s2, s3;
      bit u3;
      s2 = (g + 3) % 32; s3 = (g + 17) % 32; u3 = (g % 2 == 1);
      run_window(g, s2, s3, u3, 0, 0, 0, 0, 0, 0, 0, a, b, c, rv, rd, ce0);
      chk(ce0 == 8'(1 << (g % 8)), "R10 R3 bank_ce for slot-0 read", 256'(ce0), 256'(1 << (g % 8)));
      chk(a == expv(g, salt_m[g]), "R3 R4 operand a", a, expv(g, salt_m[g]));
      chk(b == expv(s2, salt_m[s2]), "R3 operand b", b, expv(s2, salt_m[s2]));
      e = u3 ? expv(s3, salt_m[s3]) : '0;
      chk(c == e, "R2 operand c", c, e);
    end
    // R4 register 0 after a result write
    do_write(0, 5);
    run_window(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, a, b, c, rv, rd, ce0);
    chk(a[63:0] == 64'd0 && a[255:64] == pat(0, 5)[255:64], "R4 register 0 zero", a, expv(0, 5));
    // R6 forwarding of a result taken in the same slot-0 cycle
    e = expv(7, salt_m[7]);
    run_window(7, 7, 7, 1, 1, 7, 9, 0, 0, 0, 0, a, b, c, rv, rd, ce0);
    chk(a == e, "R6 slot-0 read before pending", a, e);
    chk(b == expv(7, 9), "R6 forwarded operand b", b, expv(7, 9));
    chk(c == expv(7, 9), "R6 forwarded operand c", c, expv(7, 9));
    salt_m[7] = 9;
    // R8 store in a window without a third operand
    run_window(2, 3, 4, 0, 0, 0, 0, 1, 0, 9, 0, a, b, c, rv, rd, ce0);
    chk(rv == 1'b1, "R8 store answered in same window", 256'(rv), 256'(1));
    chk(rd == expv(9, salt_m[9]), "R8 store data", rd, expv(9, salt_m[9]));
    // R7 store blocked by a third-operand window
    run_window(2, 3, 4, 1, 0, 0, 0, 1, 0, 10, 0, a, b, c, rv, rd, ce0);
    chk(rv == 1'b0 && mem_req_ready == 1'b0, "R7 store held during busy slot",
        256'({rv, mem_req_ready}), 256'(0));
    n = 0;
    do begin @(negedge clk); n++; end while (!mem_rvalid && n < 10);
    chk(n == 4, "R7 store served one window later", 256'(n), 256'(4));
    chk(mem_rdata == expv(10, salt_m[10]), "R8 delayed store data", mem_rdata, expv(10, salt_m[10]));
    // R9 load forwarded while held, then committed
    e = expv(12, salt_m[12]);
    run_window(12, 12, 0, 0, 0, 0, 0, 1, 1, 12, 7, a, b, c, rv, rd, ce0);
    chk(a == e, "R9 slot-0 read before load held", a, e);
    chk(b == expv(12, 7), "R9 held load forwarded", b, expv(12, 7));
    chk(c == '0 && rv == 1'b0, "R9 no store answer for load", c, '0);
    salt_m[12] = 7;
    run_window(12, 13, 14, 1, 0, 0, 0, 0, 0, 0, 0, a, b, c, rv, rd, ce0);
    chk(a == expv(12, 7), "R9 load committed", a, expv(12, 7));
    chk(c == expv(14, salt_m[14]), "R2 third operand", c, expv(14, salt_m[14]));
    // R4 register 0 after a load write
    run_window(5, 6, 0, 0, 0, 0, 0, 1, 1, 0, 11, a, b, c, rv, rd, ce0);
    run_window(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, a, b, c, rv, rd, ce0);
    chk(a == expv(0, 11), "R4 load into group 0", a, expv(0, 11));
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule